// File: doc/BRIEF.md
# Multi-Line Receive Silo with Alarm

This block gathers characters from up to sixteen serial receivers (eight by default) into one shared first-in first-out store of 64 entries, the silo. Each receiver hands over a character with a one-cycle strobe that also carries its parity-error, framing-error and break indications. The receiver cannot be stalled. Each line has a one-character holding slot. A round-robin scanner moves one held character per clock into the silo. It tags the character with its line number and its error flags.

The host side is a valid/ready stream folded into one word. Bit 15 of `rbuf_word` is the valid flag. Holding `rbuf_pop` high for one clock while the flag is set consumes the head entry. A pop while the flag is clear is legal and does nothing. The host drains the silo by popping until the valid flag reads clear. Back-pressure cannot reach the receivers: a character that finds the silo full is lost, and the loss is reported on the next stored entry.

A three-bit control word turns scanning on, enables the receive interrupt and selects alarm mode. In alarm mode the interrupt waits until 16 characters have arrived since the host last popped an entry.

Top module: `mlrx_silo`

## Requirements
- R1: During and directly after reset, `rbuf_word` is 0 and `rx_irq` is 0, and all three control bits are clear.
- R2: The silo holds up to 64 entries and returns them in arrival order. A character reaches `rbuf_word` two clocks after its strobe when the silo was empty and no other line was waiting.
- R3: Field positions in `rbuf_word`: [7:0] character, [11:8] line number, [12] parity error, [13] framing error, [14] overrun, [15] valid. When valid is 0, the whole word is 0.
- R4: A pop while the silo is empty is ignored. This holds even in the clock where a character is being written, and that character stays readable afterwards.
- R5: A character taken from a line while the silo is full is discarded. The next entry that is stored has its overrun bit set.
- R6: A strobe with the break flag set is stored as character 0x00 with the framing-error bit set and the parity-error bit clear, whatever data accompanied it.
- R7: If a line strobes again while its previous character is still held and is not taken in that clock, the older character is lost. The newer one carries the overrun bit.
- R8: When several lines hold characters, one is taken per clock. The search starts at the line after the last one taken and wraps around. After the scanner is disabled, the search restarts at line 0.
- R9: With alarm mode off, `rx_irq` is 1 exactly when scanning and the interrupt are enabled and the silo is non-empty. With the interrupt disabled, `rx_irq` is 0.
- R10: With alarm mode on, `rx_irq` rises only once 16 characters have been stored since the last effective pop. An effective pop restarts that count, so `rx_irq` can rise again later.
- R11: While scanning is disabled, the silo, the holding slots and the overrun memory are cleared, and strobes are ignored. Control word bits: [0] scan enable, [1] receive interrupt enable, [2] alarm enable. A write takes effect in the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ln_stb | input | NUM_LINES | Per-line one-cycle character strobe |
| ln_data | input | NUM_LINES*8 | Per-line character, line i in bits [8i+7:8i] |
| ln_fe | input | NUM_LINES | Per-line framing error, valid with strobe |
| ln_pe | input | NUM_LINES | Per-line parity error, valid with strobe |
| ln_brk | input | NUM_LINES | Per-line break indication, valid with strobe |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 3 | Control word: scan enable, interrupt enable, alarm enable |
| rbuf_pop | input | 1 | Host ready: consume the head entry |
| rbuf_word | output | 16 | Head entry with valid flag |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The properties treat every pattern on the strobes, pop and control inputs as legal, so they place no constraint on the stimulus. Two things are taken for granted. The control register is the only source of the scan enable and interrupt enables. At most one entry enters the silo per clock, so the fill level can move by only one in either direction. The stimulus includes the cases that break a simpler design. It drives strobes on several lines in one clock and re-strobes a line before it has been taken. It pops on an empty silo in the same clock as a write. It overfills the silo and toggles the control word while data is queued. Every sequence is a legal input pattern.

// File: rtl/mlrx_pkg.sv
package mlrx_pkg;
  localparam int CHAR_W = 8;
  localparam int TAG_W  = 4;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic              ovr;
    logic              fe;
    logic              pe;
    logic [TAG_W-1:0]  line;
    logic [CHAR_W-1:0] data;
  } silo_entry_t;
endpackage

// File: rtl/mlrx_line_hold.sv
module mlrx_line_hold
  import mlrx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              stb,
  input  logic [CHAR_W-1:0] chr,
  input  logic              fe_in,
  input  logic              pe_in,
  input  logic              brk_in,
  input  logic              take,
  output logic              held,
  output logic              h_ovr,
  output logic              h_fe,
  output logic              h_pe,
  output logic [CHAR_W-1:0] h_data
);
  // one-character slot; a fresh strobe overwrites an untaken character
  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      held   <= 1'b0;
      h_ovr  <= 1'b0;
      h_fe   <= 1'b0;
      h_pe   <= 1'b0;
      h_data <= '0;
    end else if (stb) begin
      held   <= 1'b1;
      h_ovr  <= held & ~take;
      h_fe   <= fe_in | brk_in;
      h_pe   <= pe_in & ~brk_in;
      h_data <= brk_in ? '0 : chr;
    end else if (take) begin
      held   <= 1'b0;
    end
  end
endmodule

// File: rtl/mlrx_rr_arb.sv
module mlrx_rr_arb #(
  parameter int N = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [N-1:0]  req,
  output logic          gnt_vld,
  output logic [((N>1)?$clog2(N):1)-1:0] gnt_idx
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr;

  always_comb begin
    gnt_vld = 1'b0;
    gnt_idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      int ix;
      ix = int'(ptr) + k;
      if (ix >= N) ix = ix - N;
      if (req[ix]) begin
        gnt_vld = 1'b1;
        gnt_idx = IW'(ix);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) ptr <= '0;
    else if (gnt_vld) ptr <= (gnt_idx == IW'(N - 1)) ? '0 : gnt_idx + 1'b1;
  end
endmodule

// File: rtl/mlrx_silo_fifo.sv
module mlrx_silo_fifo
  import mlrx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        wr_en,
  input  silo_entry_t wr_ent,
  input  logic        rd_en,
  output silo_entry_t head,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic        full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  silo_entry_t   mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_wr, do_rd;

  assign full  = (fill == CW'(DEPTH));
  assign do_wr = wr_en & ~full;
  assign do_rd = rd_en & (fill != '0);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr && !clr) mem[wr_ptr] <= wr_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end
endmodule

// File: rtl/mlrx_silo.sv
module mlrx_silo
  import mlrx_pkg::*;
#(
  parameter int NUM_LINES   = 8,
  parameter int DEPTH       = 64,
  parameter int ALARM_LEVEL = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_LINES-1:0]        ln_stb,
  input  logic [NUM_LINES*CHAR_W-1:0] ln_data,
  input  logic [NUM_LINES-1:0]        ln_fe,
  input  logic [NUM_LINES-1:0]        ln_pe,
  input  logic [NUM_LINES-1:0]        ln_brk,
  input  logic                        ctrl_wr,
  input  logic [2:0]                  ctrl_wdata,
  input  logic                        rbuf_pop,
  output logic [WORD_W-1:0]           rbuf_word,
  output logic                        rx_irq
);
  // NUM_LINES must not exceed 2**TAG_W (16)
  localparam int IW   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int AL_W = $clog2(ALARM_LEVEL + 1);

  // control register
  logic scan_en, rx_ie, alarm_en;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scan_en  <= 1'b0;
      rx_ie    <= 1'b0;
      alarm_en <= 1'b0;
    end else if (ctrl_wr) begin
      scan_en  <= ctrl_wdata[0];
      rx_ie    <= ctrl_wdata[1];
      alarm_en <= ctrl_wdata[2];
    end
  end

  logic flush;
  assign flush = ~scan_en;

  // per-line holding slots
  logic [NUM_LINES-1:0] held, take, h_ovr, h_fe, h_pe;
  logic [CHAR_W-1:0]    h_data [NUM_LINES];
  logic                 gnt_vld;
  logic [IW-1:0]        gnt_idx;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    assign take[i] = gnt_vld && (gnt_idx == IW'(i));
    mlrx_line_hold u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (flush),
      .stb    (ln_stb[i] & scan_en),
      .chr    (ln_data[i*CHAR_W +: CHAR_W]),
      .fe_in  (ln_fe[i]),
      .pe_in  (ln_pe[i]),
      .brk_in (ln_brk[i]),
      .take   (take[i]),
      .held   (held[i]),
      .h_ovr  (h_ovr[i]),
      .h_fe   (h_fe[i]),
      .h_pe   (h_pe[i]),
      .h_data (h_data[i])
    );
  end

  mlrx_rr_arb #(.N(NUM_LINES)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (flush),
    .req     (held),
    .gnt_vld (gnt_vld),
    .gnt_idx (gnt_idx)
  );

  // silo write path
  logic        pend_ovr;
  silo_entry_t wr_ent, head;
  logic [CW-1:0] fill;
  logic        full, stored, pop_eff;

  always_comb begin
    wr_ent.ovr  = h_ovr[gnt_idx] | pend_ovr;
    wr_ent.fe   = h_fe[gnt_idx];
    wr_ent.pe   = h_pe[gnt_idx];
    wr_ent.line = TAG_W'(gnt_idx);
    wr_ent.data = h_data[gnt_idx];
  end

  assign stored  = gnt_vld & ~full;
  assign pop_eff = rbuf_pop & (fill != '0);

  mlrx_silo_fifo #(.DEPTH(DEPTH)) u_silo (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (flush),
    .wr_en  (gnt_vld),
    .wr_ent (wr_ent),
    .rd_en  (rbuf_pop),
    .head   (head),
    .fill   (fill),
    .full   (full)
  );

  // a character lost to a full silo is reported on the next stored one
  always_ff @(posedge clk) begin
    if (!rst_n || flush)      pend_ovr <= 1'b0;
    else if (gnt_vld && full) pend_ovr <= 1'b1;
    else if (stored)          pend_ovr <= 1'b0;
  end

  // arrivals since the last effective pop, saturating at the alarm level
  logic [AL_W-1:0] arr_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n || flush) arr_cnt <= '0;
    else if (pop_eff)    arr_cnt <= stored ? AL_W'(1) : '0;
    else if (stored && arr_cnt < AL_W'(ALARM_LEVEL)) arr_cnt <= arr_cnt + 1'b1;
  end

  logic alarm_hit, nonempty;
  assign nonempty  = (fill != '0);
  assign alarm_hit = (arr_cnt >= AL_W'(ALARM_LEVEL));
  assign rx_irq    = scan_en & rx_ie & (alarm_en ? alarm_hit : nonempty);
  assign rbuf_word = nonempty ? {1'b1, head} : '0;
endmodule

// File: rtl/mlrx_silo_chk.sv
module mlrx_silo_chk #(
  parameter int DEPTH       = 64,
  parameter int ALARM_LEVEL = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       scan_en,
  input logic                       rx_ie,
  input logic                       alarm_en,
  input logic [$clog2(DEPTH+1)-1:0] fill,
  input logic [$clog2(ALARM_LEVEL+1)-1:0] arr_cnt,
  input logic                       rbuf_pop,
  input logic [15:0]                rbuf_word,
  input logic                       rx_irq
);
  localparam int CW   = $clog2(DEPTH + 1);
  localparam int AL_W = $clog2(ALARM_LEVEL + 1);

  p_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CW'(DEPTH));

  p_empty_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0) |-> (rbuf_word == 16'h0000));

  p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && fill == CW'(DEPTH) && !rbuf_pop) |=> (fill == CW'(DEPTH)));

  p_ie_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ie |-> !rx_irq);

  p_alarm_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_en && arr_cnt < AL_W'(ALARM_LEVEL)) |-> !rx_irq);

  p_flush_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> (fill == '0));
endmodule

bind mlrx_silo mlrx_silo_chk #(.DEPTH(DEPTH), .ALARM_LEVEL(ALARM_LEVEL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scan_en   (scan_en),
  .rx_ie     (rx_ie),
  .alarm_en  (alarm_en),
  .fill      (fill),
  .arr_cnt   (arr_cnt),
  .rbuf_pop  (rbuf_pop),
  .rbuf_word (rbuf_word),
  .rx_irq    (rx_irq)
);

// File: tb/sim_mlrx_silo.sv
`timescale 1ns/1ps
module sim_mlrx_silo;
  localparam int NL    = 8;
  localparam int DEPTH = 64;
  localparam int ALARM = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NL-1:0]   ln_stb = '0;
  logic [NL*8-1:0] ln_data = '0;
  logic [NL-1:0]   ln_fe = '0, ln_pe = '0, ln_brk = '0;
  logic            ctrl_wr = 1'b0;
  logic [2:0]      ctrl_wdata = '0;
  logic            rbuf_pop = 1'b0;
  logic [15:0]     rbuf_word;
  logic            rx_irq;

  always #2.5 clk = ~clk;

  mlrx_silo #(.NUM_LINES(NL), .DEPTH(DEPTH), .ALARM_LEVEL(ALARM)) u0 (
    .clk(clk), .rst_n(rst_n), .ln_stb(ln_stb), .ln_data(ln_data),
    .ln_fe(ln_fe), .ln_pe(ln_pe), .ln_brk(ln_brk), .ctrl_wr(ctrl_wr),
    .ctrl_wdata(ctrl_wdata), .rbuf_pop(rbuf_pop), .rbuf_word(rbuf_word),
    .rx_irq(rx_irq)
  );

  int    errors = 0;
  int    checks = 0;
  string phase = "R1";
  bit    live = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [14:0] mq[$];
  bit       hv[NL], ho[NL], hf[NL], hp[NL];
  bit [7:0] hd[NL];
  int       rr, arr;
  bit       pend, m_scan, m_ie, m_al;

  task automatic model_clear();
    mq.delete();
    for (int i = 0; i < NL; i++) begin
      hv[i] = 0; ho[i] = 0; hf[i] = 0; hp[i] = 0; hd[i] = 0;
    end
    rr = 0; arr = 0; pend = 0;
  endtask

  always @(posedge clk) begin
    int  g;
    bit  gv, full, popd, stored;
    if (!rst_n) begin
      model_clear();
      m_scan = 0; m_ie = 0; m_al = 0;
    end else begin
      gv = 0; g = 0; popd = 0; stored = 0;
      if (!m_scan) model_clear();
      else begin
        for (int k = NL - 1; k >= 0; k--) begin
          int ix;
          ix = (rr + k) % NL;
          if (hv[ix]) begin gv = 1; g = ix; end
        end
        full = (mq.size() == DEPTH);
        if (rbuf_pop && mq.size() > 0) begin
          void'(mq.pop_front());
          popd = 1;
        end
        if (gv) begin
          if (full) pend = 1;
          else begin
            mq.push_back({ho[g] | pend, hf[g], hp[g], 4'(g), hd[g]});
            pend = 0;
            stored = 1;
          end
          rr = (g + 1) % NL;
        end
        if (popd) arr = stored ? 1 : 0;
        else if (stored && arr < ALARM) arr++;
        for (int i = 0; i < NL; i++) begin
          if (ln_stb[i]) begin
            ho[i] = hv[i] && !(gv && g == i);
            hv[i] = 1;
            hd[i] = ln_brk[i] ? 8'h00 : ln_data[i*8 +: 8];
            hf[i] = ln_fe[i] | ln_brk[i];
            hp[i] = ln_pe[i] & ~ln_brk[i];
          end else if (gv && g == i) hv[i] = 0;
        end
      end
      if (ctrl_wr) {m_al, m_ie, m_scan} = ctrl_wdata;
    end
  end

  // compared on every falling edge
  always @(negedge clk) begin
    logic [15:0] ew;
    bit          ei;
    if (live) begin
      ew = (mq.size() > 0) ? {1'b1, mq[0]} : 16'h0000;
      ei = m_scan && m_ie && (m_al ? (arr >= ALARM) : (mq.size() > 0));
      chk({phase, " word"}, 32'(rbuf_word), 32'(ew));
      chk({phase, " irq"}, 32'(rx_irq), 32'(ei));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(negedge clk); #1;
    ln_stb = '0; ln_fe = '0; ln_pe = '0; ln_brk = '0;
    rbuf_pop = 0; ctrl_wr = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) tick();
  endtask

  task automatic put(input int ln, input logic [7:0] d, input bit fe, input bit pe, input bit brk);
    ln_stb[ln] = 1; ln_data[ln*8 +: 8] = d;
    ln_fe[ln] = fe; ln_pe[ln] = pe; ln_brk[ln] = brk;
  endtask

  task automatic set_ctrl(input logic [2:0] v);
    ctrl_wr = 1; ctrl_wdata = v; tick();
  endtask

  int drained;
  logic [15:0] last_w;
  task automatic drain();
    drained = 0;
    while (rbuf_word[15]) begin
      last_w = rbuf_word;
      rbuf_pop = 1; drained++;
      tick();
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  // ---------------- directed sequence ----------------
  initial begin
    #1;
    wait_n(3);
    chk("R1 reset word", 32'(rbuf_word), 0);
    chk("R1 reset irq", 32'(rx_irq), 0);
    rst_n = 1;
    live = 1;
    tick();

    // R3 / R9: single character, field layout and plain interrupt
    phase = "R3";
    set_ctrl(3'b011);
    put(3, 8'h41, 0, 1, 0); tick();
    wait_n(1);
    chk("R2 latency/R3 word", 32'(rbuf_word), 32'h9341);
    chk("R9 irq nonempty", 32'(rx_irq), 1);
    phase = "R9";
    set_ctrl(3'b001); wait_n(1);
    chk("R9 irq disabled", 32'(rx_irq), 0);
    set_ctrl(3'b011);
    drain();
    chk("R9 irq empty", 32'(rx_irq), 0);

    // R8: simultaneous strobes, last served line 3 -> order 4,6,1
    phase = "R8";
    put(1, 8'h11, 0, 0, 0); put(4, 8'h44, 0, 0, 0); put(6, 8'h66, 0, 0, 0);
    tick(); wait_n(4);
    chk("R8 first line", 32'(rbuf_word[11:8]), 4);
    rbuf_pop = 1; tick();
    chk("R8 second line", 32'(rbuf_word[11:8]), 6);
    rbuf_pop = 1; tick();
    chk("R8 third line", 32'(rbuf_word[11:8]), 1);
    drain();

    // R7: all lines strobe, line 7 re-strobes before being taken
    phase = "R7";
    for (int i = 0; i < NL; i++) put(i, 8'(8'h20 + i), 0, 0, 0);
    tick();
    put(7, 8'h99, 0, 0, 0); tick();
    wait_n(10);
    for (int i = 0; i < 5; i++) begin rbuf_pop = 1; tick(); end
    chk("R7 overrun entry", 32'(rbuf_word), 32'hC799);
    drain();

    // R6: break on line 5
    phase = "R6";
    put(5, 8'h55, 0, 1, 1); tick(); wait_n(2);
    chk("R6 break word", 32'(rbuf_word), 32'hA500);
    drain();

    // R4: pop on empty, and pop on empty during a write
    phase = "R4";
    rbuf_pop = 1; tick(); wait_n(1);
    chk("R4 empty pop", 32'(rbuf_word), 0);
    put(0, 8'h5A, 0, 0, 0); tick();
    rbuf_pop = 1; tick();
    chk("R4 write survives pop", 32'(rbuf_word), 32'h805A);
    drain();

    // R2 / R5: overfill
    phase = "R5";
    for (int i = 0; i < 70; i++) begin put(i % NL, 8'(i), 0, 0, 0); tick(); end
    wait_n(3);
    rbuf_pop = 1; tick();
    put(2, 8'hEE, 0, 0, 0); tick(); wait_n(3);
    drain();
    chk("R2 capacity", 32'(drained), 64);
    chk("R5 overrun on next stored", 32'(last_w), 32'hC2EE);

    // R10: alarm mode
    phase = "R10";
    set_ctrl(3'b111);
    for (int i = 0; i < ALARM - 1; i++) begin put(i % NL, 8'(i), 0, 0, 0); tick(); end
    wait_n(3);
    chk("R10 below level", 32'(rx_irq), 0);
    put(1, 8'h77, 0, 0, 0); tick(); wait_n(3);
    chk("R10 at level", 32'(rx_irq), 1);
    rbuf_pop = 1; tick();
    chk("R10 pop restarts", 32'(rx_irq), 0);
    for (int i = 0; i < ALARM; i++) begin put(i % NL, 8'(i), 0, 0, 0); tick(); end
    wait_n(3);
    chk("R10 rises again", 32'(rx_irq), 1);
    drain();
    set_ctrl(3'b011);

    // R11: scan disable flushes and ignores strobes
    phase = "R11";
    put(0, 8'h01, 0, 0, 0); put(3, 8'h03, 0, 0, 0); tick(); wait_n(4);
    chk("R11 data before off", 32'(rbuf_word[15]), 1);
    set_ctrl(3'b010); wait_n(2);
    chk("R11 flushed", 32'(rbuf_word), 0);
    put(6, 8'h66, 0, 0, 0); tick(); wait_n(3);
    chk("R11 strobe ignored", 32'(rbuf_word), 0);
    set_ctrl(3'b011); wait_n(3);
    chk("R11 nothing after re-enable", 32'(rbuf_word), 0);
    chk("R11 irq", 32'(rx_irq), 0);

    live = 0;
    finish_run();
  end
endmodule